// File: doc/BRIEF.md
# Two-Road Demand-Driven Traffic Light Controller

This block runs the lights at a crossing of a North-South road and an East-West road. Each road has a single light that shows either green or red, and exactly one of the two roads holds green at any moment. One car detector per road reports whether a car is waiting. An internal interval counter divides the system clock into a one-cycle decision tick. On each tick the controller compares the detectors with the road that currently holds green. It hands green to the other road only when a car is waiting there.

The controller has two states, and the state value drives the lights directly. The default interval is set for a 30 second update period at a 100 MHz clock. A shorter interval can be set for simulation. Amber phases, pedestrian requests and detector filtering are not part of the block.

Top module: `tl_crossing_ctrl`

## Requirements
- R1: The `phase` output encodes the state: 0 means North-South holds green and 1 means East-West holds green. `green_ns` is 1 exactly when `phase` is 0, and `green_ew` is 1 exactly when `phase` is 1. A light whose green output is 0 shows red.
- R2: In every clock cycle exactly one of `green_ns` and `green_ew` is 1, so both roads are never red together and never green together.
- R3: `phase` changes only on a decision edge, which is the rising edge that ends a tick cycle. On every other edge it keeps its value.
- R4: On a decision edge with North-South holding green, the state moves to East-West green if `car_ew` is 1, whatever `car_ns` shows. Otherwise it stays at North-South green, and this includes the case where neither road has a car.
- R5: On a decision edge with East-West holding green, the state moves to North-South green if `car_ns` is 1, whatever `car_ew` shows. Otherwise it stays at East-West green, and this includes the case where neither road has a car.
- R6: A decision edge occurs on every TICKS_PER_UPDATE-th rising clock edge. The first one is the TICKS_PER_UPDATE-th rising edge at which `rst` is sampled low after reset.
- R7: Detector values present in any cycle other than the tick cycle have no effect on `phase` or on the lights.
- R8: When `rst` is sampled high on a rising edge, the state becomes North-South green and the interval count restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| car_ns | input | 1 | A car is waiting on the North-South road |
| car_ew | input | 1 | A car is waiting on the East-West road |
| green_ns | output | 1 | North-South light: 1 is green, 0 is red |
| green_ew | output | 1 | East-West light: 1 is green, 0 is red |
| phase | output | 1 | Current state: 0 is North-South green, 1 is East-West green |

## Verification
The assertions assume that both detector inputs are already synchronous to `clk` and hold known values at every rising edge, because the block does no filtering or synchronising of its own. They also assume that `rst` is driven low or high at time zero, which lets the reset property hold from the first edge. The bench meets these assumptions by changing the detectors and the reset only on falling edges. In every cycle of an interval except the tick cycle, it drives the opposite of the detector values it intends to have sampled. This shows that values outside the tick cycle are ignored and keeps every transition inside the sampling rule.

// File: rtl/tl_pkg.sv
package tl_pkg;

  typedef enum logic {
    PH_NS = 1'b0,
    PH_EW = 1'b1
  } phase_e;

  // Next state on a decision edge: green moves only toward a waiting car
  function automatic phase_e tl_next_phase(phase_e cur, logic car_ns, logic car_ew);
    phase_e nxt;
    nxt = cur;
    case (cur)
      PH_NS:   if (car_ew) nxt = PH_EW;
      PH_EW:   if (car_ns) nxt = PH_NS;
      default: nxt = PH_NS;
    endcase
    return nxt;
  endfunction

  // Light decode, returned as {green_ew, green_ns}
  function automatic logic [1:0] tl_lights(phase_e cur);
    return (cur == PH_EW) ? 2'b10 : 2'b01;
  endfunction

endpackage

// File: rtl/tl_interval_timer.sv
module tl_interval_timer #(
  parameter int unsigned TICKS_PER_UPDATE = 32'd3_000_000_000
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int unsigned CNT_W = (TICKS_PER_UPDATE > 1) ? $clog2(TICKS_PER_UPDATE) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS_PER_UPDATE - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             at_last;

  assign at_last = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (at_last) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tick = at_last;
endmodule

// File: rtl/tl_phase_reg.sv
module tl_phase_reg
  import tl_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   tick,
  input  logic   car_ns,
  input  logic   car_ew,
  output phase_e phase_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_NS;
    end else if (tick) begin
      phase_q <= tl_next_phase(phase_q, car_ns, car_ew);
    end
  end
endmodule

// File: rtl/tl_light_drv.sv
module tl_light_drv
  import tl_pkg::*;
(
  input  phase_e cur,
  output logic   green_ns,
  output logic   green_ew
);
  logic [1:0] lamp;

  always_comb begin
    lamp = tl_lights(cur);
  end

  assign green_ns = lamp[0];
  assign green_ew = lamp[1];
endmodule

// File: rtl/tl_crossing_ctrl.sv
module tl_crossing_ctrl
  import tl_pkg::*;
#(
  parameter int unsigned TICKS_PER_UPDATE = 32'd3_000_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic car_ns,
  input  logic car_ew,
  output logic green_ns,
  output logic green_ew,
  output logic phase
);
  logic   upd_tick;
  phase_e phase_cur;

  tl_interval_timer #(
    .TICKS_PER_UPDATE(TICKS_PER_UPDATE)
  ) u_timer (
    .clk  (clk),
    .rst  (rst),
    .tick (upd_tick)
  );

  tl_phase_reg u_state (
    .clk     (clk),
    .rst     (rst),
    .tick    (upd_tick),
    .car_ns  (car_ns),
    .car_ew  (car_ew),
    .phase_q (phase_cur)
  );

  tl_light_drv u_lights (
    .cur      (phase_cur),
    .green_ns (green_ns),
    .green_ew (green_ew)
  );

  assign phase = phase_cur;
endmodule

// File: rtl/tl_crossing_chk.sv
module tl_crossing_chk #(
  parameter int unsigned TICKS_PER_UPDATE = 32'd3_000_000_000
) (
  input logic clk,
  input logic rst,
  input logic tick,
  input logic car_ns,
  input logic car_ew,
  input logic green_ns,
  input logic green_ew,
  input logic phase
);
  localparam int unsigned CW = (TICKS_PER_UPDATE > 1) ? $clog2(TICKS_PER_UPDATE) : 1;
  localparam logic [CW-1:0] WRAP = CW'(TICKS_PER_UPDATE - 1);

  // Free-running shadow count, wrapped on its own terminal value, not on tick
  logic [CW-1:0] shadow_q;
  always_ff @(posedge clk) begin
    if (rst)                   shadow_q <= '0;
    else if (shadow_q == WRAP) shadow_q <= '0;
    else                       shadow_q <= shadow_q + 1'b1;
  end

  p_lamp_match_r1: assert property (@(posedge clk) disable iff (rst)
    (green_ns == !phase) && (green_ew == phase));

  p_one_green_r2: assert property (@(posedge clk) disable iff (rst)
    $countones({green_ns, green_ew}) == 1);

  p_hold_between_r3: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(phase));

  p_ns_handover_r4: assert property (@(posedge clk) disable iff (rst)
    (tick && !phase && car_ew) |=> phase);

  p_ns_keep_r4: assert property (@(posedge clk) disable iff (rst)
    (tick && !phase && !car_ew) |=> !phase);

  p_ew_handover_r5: assert property (@(posedge clk) disable iff (rst)
    (tick && phase && car_ns) |=> !phase);

  p_ew_keep_r5: assert property (@(posedge clk) disable iff (rst)
    (tick && phase && !car_ns) |=> phase);

  p_tick_period_r6: assert property (@(posedge clk) disable iff (rst)
    tick == (shadow_q == WRAP));

  p_reset_state_r8: assert property (@(posedge clk)
    rst |=> (!phase && green_ns));
endmodule

bind tl_crossing_ctrl tl_crossing_chk #(
  .TICKS_PER_UPDATE(TICKS_PER_UPDATE)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .tick     (upd_tick),
  .car_ns   (car_ns),
  .car_ew   (car_ew),
  .green_ns (green_ns),
  .green_ew (green_ew),
  .phase    (phase)
);

// File: tb/test_tl_crossing_ctrl.sv
`timescale 1ns/1ps
module test_tl_crossing_ctrl;
  localparam int unsigned N = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic car_ns = 1'b0;
  logic car_ew = 1'b0;
  logic green_ns, green_ew, phase;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic exp_q[$];
  logic model_phase = 1'b0;

  always #2 clk = ~clk;

  tl_crossing_ctrl #(.TICKS_PER_UPDATE(N)) i_tl_crossing_ctrl (
    .clk      (clk),
    .rst      (rst),
    .car_ns   (car_ns),
    .car_ew   (car_ew),
    .green_ns (green_ns),
    .green_ew (green_ew),
    .phase    (phase)
  );

  task automatic check(input bit ok, input string req, input logic act, input logic exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  // Driver: one full interval. Starts on a falling edge and ends on one.
  // Every cycle except the tick cycle carries the inverted detector values (R7).
  task automatic run_interval(input logic ns, input logic ew);
    for (int k = 0; k < int'(N); k++) begin
      if (k == int'(N) - 1) begin
        car_ns = ns;
        car_ew = ew;
        if (model_phase == 1'b0) model_phase = ew ? 1'b1 : 1'b0;   // R4 rule
        else                     model_phase = ns ? 1'b0 : 1'b1;   // R5 rule
        exp_q.push_back(model_phase);
      end else begin
        car_ns = ~ns;
        car_ew = ~ew;
      end
      @(negedge clk);
    end
  endtask

  // Monitor / scoreboard, sampling 1 ns after each rising edge
  initial begin
    int edge_cnt = 0;
    logic last = 1'b0;
    logic exp;
    forever begin
      @(posedge clk);
      #1;
      check(green_ns ^ green_ew, "R2 one green", green_ns, ~green_ew);
      check(green_ew == phase && green_ns == ~phase, "R1 lights follow phase", green_ew, phase);
      if (rst) begin
        edge_cnt = 0;
        check(phase == 1'b0, "R8 reset to NS green", phase, 1'b0);
        last = 1'b0;
      end else begin
        edge_cnt++;
        if (edge_cnt == int'(N)) begin
          edge_cnt = 0;
          if (exp_q.size() == 0) begin
            check(1'b0, "R6 decision with no expected item", phase, last);
          end else begin
            exp = exp_q.pop_front();
            check(phase == exp, last ? "R5 decision from EW" : "R4 decision from NS", phase, exp);
          end
        end else begin
          check(phase == last, "R3/R7 hold between ticks", phase, last);
        end
        last = phase;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // All eight table rows (R4, R5)
    run_interval(1'b0, 1'b0);  // NS stays
    run_interval(1'b1, 1'b0);  // NS stays
    run_interval(1'b0, 1'b1);  // to EW
    run_interval(1'b0, 1'b0);  // EW stays
    run_interval(1'b0, 1'b1);  // EW stays
    run_interval(1'b1, 1'b0);  // to NS
    run_interval(1'b1, 1'b1);  // to EW
    run_interval(1'b1, 1'b1);  // to NS
    run_interval(1'b0, 1'b1);  // to EW
    // Mid-interval reset while EW holds green (R8), then timer restart (R6)
    car_ns = 1'b1; car_ew = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b1;
    model_phase = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    run_interval(1'b0, 1'b0);  // NS stays
    run_interval(1'b0, 1'b1);  // to EW
    run_interval(1'b1, 1'b0);  // to NS
    repeat (2) @(negedge clk);
    check(exp_q.size() == 0, "R6 all decisions seen", 1'b0, 1'b0);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #40000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule